// File: doc/BRIEF.md
# Mode Register Load Timing Guard

This block sits between a memory controller's command request port and the command bus of a DDR memory. It enforces the legality and spacing rules around loading the mode register or the extended mode register. The requester presents one command with its bank and address. The guard grants it with `req_ready` only when the timing allows. A request that is not granted is stalled, and the requester keeps presenting it until it is accepted.

The guard keeps a bitmap of open banks and a recovery window that starts at each precharge. It also keeps a spacing window after each mode load. When the mode load sets the clock-alignment-loop reset bit (address bit 8), the spacing window is lengthened by a long lockout, and `busy` stays high for all of it. Granted commands reach the command bus one cycle after the grant. In every other cycle the bus carries NOP.

Top module: `mrs_guard`

## Requirements
- R1: After reset, `cmd_out` is NOP (0) with `cmd_bank` and `cmd_addr` at zero, `busy` is low, every bank counts as closed, and no timing window is pending.
- R2: Command codes are NOP=0, ACT=1, PRE (one bank)=2, PREALL=3, MRS=4, EMRS=5, RD=6, WR=7. A request granted in cycle t (`req_valid` and `req_ready` both high) shows up on `cmd_out`/`cmd_bank`/`cmd_addr` in cycle t+1. A cycle that follows a cycle with no grant carries NOP with zero bank and address.
- R3: A granted ACT marks its bank open. A granted PRE closes only its own bank. A granted PREALL closes all banks. RD, WR and NOP leave the bank state unchanged.
- R4: An MRS or EMRS request is refused (`req_ready` low) while any bank is open. The refusal lasts until the request can be granted, and the request is not consumed.
- R5: After a PRE or PREALL is granted in cycle t, an MRS or EMRS cannot be granted before cycle t+T_PRECH (default 3).
- R6: After an MRS or EMRS with address bit 8 clear is granted in cycle t, no command is granted before cycle t+T_MODE (default 2). `busy` is high in cycles t+1 through t+T_MODE-1.
- R7: After an MRS or EMRS with address bit 8 set is granted in cycle t, no command is granted before cycle t+T_MODE+T_LOCK (T_LOCK default 200). `busy` is high in cycles t+1 through t+T_MODE+T_LOCK-1.
- R8: ACT, PRE, PREALL, RD, WR and NOP are gated only by the mode-load window. Open banks and precharge recovery do not hold them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Requested bank |
| req_addr | input | ADDR_W | Requested address / mode value |
| req_ready | output | 1 | Request may be granted this cycle |
| cmd_out | output | 3 | Command driven to memory |
| cmd_bank | output | BANK_W | Bank driven to memory |
| cmd_addr | output | ADDR_W | Address driven to memory |
| busy | output | 1 | Mode-load spacing or lockout active |

## Verification
`req_ready` is combinational on the current request and state. The bench drives each request on the falling edge and samples `req_ready` one nanosecond later, in the same cycle. The command bus and `busy` are registered, so they are sampled one nanosecond after the rising edge that makes the grant. The reference model records the earliest cycle at which each window closes, and this is compared with a cycle counter. The boundaries of R5, R6 and R7 are checked exactly: a mode load is probed in every cycle of the recovery window, and the full 202-cycle lockout is walked cycle by cycle.

// File: rtl/mrs_guard.sv
module mrs_guard #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int T_PRECH   = 3,
  parameter int T_MODE    = 2,
  parameter int T_LOCK    = 200,
  parameter int LOOP_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [2:0]        cmd_out,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy
);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_PALL = 3'd3,
                         C_MRS = 3'd4, C_EMRS = 3'd5;
  localparam int WAIT_W = $clog2(T_MODE + T_LOCK + 1);
  localparam int RP_W   = $clog2(T_PRECH + 1);
  localparam logic [WAIT_W-1:0] SHORT_LD = WAIT_W'(T_MODE - 1);
  localparam logic [WAIT_W-1:0] LONG_LD  = WAIT_W'(T_MODE + T_LOCK - 1);
  localparam logic [RP_W-1:0]   RP_LD    = RP_W'(T_PRECH - 1);

  logic [NUM_BANKS-1:0] open_q;
  logic [WAIT_W-1:0]    wait_q;
  logic [RP_W-1:0]      rp_q;

  wire is_mode = (req_cmd == C_MRS) || (req_cmd == C_EMRS);
  wire mode_ok = (open_q == '0) && (rp_q == '0);
  wire grant   = req_valid && req_ready;

  assign req_ready = (wait_q == '0) && (!is_mode || mode_ok);
  assign busy      = (wait_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= '0;
      wait_q   <= '0;
      rp_q     <= '0;
      cmd_out  <= C_NOP;
      cmd_bank <= '0;
      cmd_addr <= '0;
    end else begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      if (rp_q != '0)   rp_q   <= rp_q - 1'b1;
      cmd_out  <= grant ? req_cmd  : C_NOP;
      cmd_bank <= grant ? req_bank : '0;
      cmd_addr <= grant ? req_addr : '0;
      if (grant) begin
        case (req_cmd)
          C_ACT:  open_q[req_bank] <= 1'b1;
          C_PRE:  begin open_q[req_bank] <= 1'b0; rp_q <= RP_LD; end
          C_PALL: begin open_q <= '0; rp_q <= RP_LD; end
          C_MRS, C_EMRS: wait_q <= req_addr[LOOP_BIT] ? LONG_LD : SHORT_LD;
          default: ;
        endcase
      end
    end
  end
endmodule

module mrs_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  parameter int LOOP_BIT  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [2:0]           req_cmd,
  input logic [BANK_W-1:0]    req_bank,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_ready,
  input logic [2:0]           cmd_out,
  input logic                 busy,
  input logic [NUM_BANKS-1:0] open_q
);
  wire g    = req_valid && req_ready;
  wire mode = (req_cmd == 3'd4) || (req_cmd == 3'd5);

  // R2
  grant_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g |=> cmd_out == $past(req_cmd));
  // R2
  idle_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !g |=> cmd_out == 3'd0);
  // R4
  mode_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g && mode) |-> open_q == '0);
  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R7
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g && mode && req_addr[LOOP_BIT]) |=> busy);
  // R3
  act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g && req_cmd == 3'd1) |=> open_q != '0);
endmodule

bind mrs_guard mrs_guard_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
  .LOOP_BIT(LOOP_BIT)) u_chk (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_cmd(req_cmd), .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
  .cmd_out(cmd_out), .busy(busy), .open_q(open_q));

// File: tb/tb_mrs_guard.sv
module tb_mrs_guard;
  localparam int NB = 4, T_PRECH = 3, T_MODE = 2, T_LOCK = 200;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [2:0] req_cmd = 0;
  logic [1:0] req_bank = 0;
  logic [12:0] req_addr = 0;
  logic req_ready, busy;
  logic [2:0] cmd_out;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  int checks = 0, errors = 0;
  longint cyc = 0, pre_ok = 0, release_at = 0;
  logic [NB-1:0] open_m = '0;
  bit done = 0;

  mrs_guard dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready), .cmd_out(cmd_out),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit is_mode(input logic [2:0] c);
    return c == 3'd4 || c == 3'd5;
  endfunction

  function automatic bit exp_ready(input logic [2:0] c);
    if (cyc < release_at) return 0;
    if (is_mode(c)) return (open_m == '0) && (cyc >= pre_ok);
    return 1;
  endfunction

  function automatic string ready_tag(input logic [2:0] c);
    if (cyc < release_at) return "R6/R7";
    if (is_mode(c) && open_m != '0) return "R4";
    if (is_mode(c)) return "R5";
    return "R8";
  endfunction

  bit lock_on = 0;

  task automatic step(input bit v, input logic [2:0] c, input logic [1:0] b, input logic [12:0] a);
    bit er, g;
    @(negedge clk);
    req_valid = v; req_cmd = c; req_bank = b; req_addr = a;
    #1;
    er = exp_ready(c);
    chk(req_ready == er, ready_tag(c), req_ready, er);
    g = v && er;
    @(posedge clk); #1;
    if (g) begin
      case (c)
        3'd1: open_m[b] = 1;
        3'd2: begin open_m[b] = 0; pre_ok = cyc + T_PRECH; end
        3'd3: begin open_m = '0; pre_ok = cyc + T_PRECH; end
        3'd4, 3'd5: begin
          lock_on = a[8];
          release_at = cyc + T_MODE + (a[8] ? T_LOCK : 0);
        end
        default: ;
      endcase
    end
    cyc++;
    chk(cmd_out == (g ? c : 3'd0), "R2", cmd_out, g ? c : 3'd0);
    chk(cmd_bank == (g ? b : 2'd0) && cmd_addr == (g ? a : 13'd0), "R2", cmd_addr, g ? a : 0);
    chk(busy == (cyc < release_at), lock_on ? "R7" : "R6", busy, cyc < release_at);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    chk(cmd_out == 0 && cmd_bank == 0 && cmd_addr == 0, "R1", cmd_out, 0);
    chk(busy == 0, "R1", busy, 0);
    @(negedge clk); rst_n = 1;
    // R1: mode load allowed at once after reset (no bank open, nothing pending)
    step(1, 3'd4, 0, 13'h033);
    step(1, 3'd6, 0, 0);            // R6 blocked cycle
    step(1, 3'd1, 2, 13'h010);      // R8 act after spacing
    step(1, 3'd6, 1, 0);            // R3 read changes nothing
    step(1, 3'd5, 0, 13'h001);      // R4 refused
    step(1, 3'd5, 0, 13'h001);      // R4 still held
    step(1, 3'd2, 1, 0);            // R3 precharge of a closed bank
    step(1, 3'd5, 0, 13'h001);      // R4 bank 2 still open
    step(1, 3'd2, 2, 0);            // R3 close bank 2
    for (int i = 0; i < 4; i++) step(1, 3'd4, 0, 13'h100); // R5 window then R7 grant
    for (int i = 0; i < T_LOCK + T_MODE + 2; i++) step(1, 3'd1, 0, 0); // R7 lockout
    step(1, 3'd3, 0, 0);            // R3 precharge-all
    step(1, 3'd4, 0, 0);            // R5 early
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [2:0] c;
      logic [12:0] a = 13'($urandom);
      if (r < 25) c = 3'd1;
      else if (r < 40) c = 3'd2;
      else if (r < 50) c = 3'd3;
      else if (r < 70) c = 3'($urandom_range(4, 5));
      else c = 3'($urandom_range(6, 7));
      if ($urandom_range(0, 15) != 0) a[8] = 0;
      step($urandom_range(0, 7) != 0, c, 2'($urandom), a);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule